// File: doc/BRIEF.md
# Receive FIFO Controller over a Shared Slot Pool

This block keeps the bookkeeping for a receive FIFO that is carved out of a pool of eight message slots. The two lowest slots always receive. Each of the six slots above them is set by its own direction bit to transmit or to receive. The FIFO holds only the unbroken run of receive slots that starts at slot 0, so its depth ends just before the first programmable slot marked as transmit. The block does not store message contents. It tracks which slots hold unread messages, where the next accepted message lands, and which slot software reads next.

Each pulse on `accept` means that a message was written into the slot at `wr_ptr`. Software reads the slot named by `rd_ptr` and then pulses `clr_full` with that slot number. This releases the slot and moves the read pointer forward. The block raises a receive interrupt with a fixed code while any message is unread. It also raises a level warning when the free space drops to a chosen threshold, and it keeps a sticky flag when a message had to be dropped.

Top module: `rxfifo_pool`

## Requirements
- R1: `depth` equals 2 plus the index (0..5) of the lowest set bit of `slot_is_tx`, or 8 when no bit is set.
- R2: An `accept` while the slot at `wr_ptr` is not full sets that slot's bit in `full_flags` and advances `wr_ptr` by one, wrapping from `depth`-1 to 0.
- R3: An `accept` while the slot at `wr_ptr` is full is dropped and sets `overflow`, which then stays high until reset or a direction change.
- R4: A `clr_full` pulse with `clr_slot` equal to `rd_ptr` while that slot is full clears its bit and advances `rd_ptr` by one, wrapping from `depth`-1 to 0.
- R5: A `clr_full` pulse that names any other slot, or that arrives while the FIFO is empty, changes neither the flags nor the pointers.
- R6: `empty` is high exactly when the slot at `rd_ptr` is not full. `rx_irq` is its inverse, and `irq_code` is 5'b10000 while `rx_irq` is high and 5'b00000 otherwise.
- R7: `wm_irq` is high while the FIFO holds at least one message and the number of free slots (`depth` minus full slots) is at or below the threshold. The threshold is 1 when `wm_one` is 1 and 4 when `wm_one` is 0.
- R8: In the cycle after any bit of `slot_is_tx` changes, both pointers are 0, all flags are clear and `overflow` is low. Any accept or clear presented in the cycle of the change is ignored.
- R9: After reset, the pointers, flags and `overflow` are zero, `empty` is high, and no interrupt is raised.
- R10: With the configuration stable, only slots below `depth` are ever full, and both pointers stay below `depth`.
- R11: An accept and a head clear in the same cycle both take effect. If the FIFO was full at that moment, the accept is dropped (R3) even though the clear frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_is_tx | input | 6 | Direction of programmable slots 2..7, 1 = transmit |
| wm_one | input | 1 | Warning threshold select: 1 = one free slot, 0 = four |
| accept | input | 1 | A message was accepted into the slot at `wr_ptr` |
| clr_full | input | 1 | Software releases the slot named by `clr_slot` |
| clr_slot | input | 4 | Slot number being released |
| full_flags | output | 8 | Per-slot full flag |
| wr_ptr | output | 4 | Slot that receives the next message |
| rd_ptr | output | 4 | Oldest unread slot |
| depth | output | 4 | Active FIFO depth |
| empty | output | 1 | No unread message at `rd_ptr` |
| rx_irq | output | 1 | Receive interrupt |
| irq_code | output | 5 | Interrupt code, 10000 on receive |
| wm_irq | output | 1 | Free-space warning |
| overflow | output | 1 | Sticky drop indicator |

## Verification
The hardest states to reach are those at the edge of a short FIFO. Examples are a full FIFO that gets an accept and a head clear in the same cycle, and pointers that wrap at a depth of 2, 3 or 7 instead of 8. The bench walks through a list of direction patterns, including ones whose later transmit bits must not matter. Under each pattern it overfills the FIFO, tries releases aimed at the wrong slot, drains it, and then streams paired accept-and-clear cycles past the wrap point several times. Each new pattern is applied while the FIFO still holds messages and a set overflow flag, so every reconfiguration has state to wipe.

// File: rtl/rxfifo_pool.sv
module rxfifo_pool #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_DED   = 2,
  parameter int PTR_W     = 4,
  parameter logic [4:0] RX_CODE = 5'b10000,
  localparam int NUM_PROG = NUM_SLOTS - NUM_DED
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PROG-1:0] slot_is_tx,
  input  logic                wm_one,
  input  logic                accept,
  input  logic                clr_full,
  input  logic [PTR_W-1:0]    clr_slot,
  output logic [NUM_SLOTS-1:0] full_flags,
  output logic [PTR_W-1:0]    wr_ptr,
  output logic [PTR_W-1:0]    rd_ptr,
  output logic [PTR_W-1:0]    depth,
  output logic                empty,
  output logic                rx_irq,
  output logic [4:0]          irq_code,
  output logic                wm_irq,
  output logic                overflow
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  logic [NUM_PROG-1:0] cfg_q;
  logic [PTR_W-1:0]    used, free_cnt, wr_nxt, rd_nxt;
  logic [IDX_W-1:0]    wr_idx, rd_idx;
  logic                reconfig, do_wr, do_rd;

  always_comb begin
    depth = PTR_W'(NUM_SLOTS);
    for (int i = NUM_PROG - 1; i >= 0; i--)
      if (slot_is_tx[i]) depth = PTR_W'(NUM_DED + i);
  end

  always_comb begin
    used = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      used = used + PTR_W'(full_flags[i]);
  end

  assign reconfig = cfg_q != slot_is_tx;
  assign wr_idx   = wr_ptr[IDX_W-1:0];
  assign rd_idx   = rd_ptr[IDX_W-1:0];
  assign wr_nxt   = (wr_ptr == depth - PTR_W'(1)) ? '0 : wr_ptr + PTR_W'(1);
  assign rd_nxt   = (rd_ptr == depth - PTR_W'(1)) ? '0 : rd_ptr + PTR_W'(1);
  assign do_wr    = accept && !full_flags[wr_idx];
  assign do_rd    = clr_full && (clr_slot == rd_ptr) && full_flags[rd_idx];
  assign free_cnt = depth - used;

  assign empty    = !full_flags[rd_idx];
  assign rx_irq   = !empty;
  assign irq_code = rx_irq ? RX_CODE : 5'b00000;
  assign wm_irq   = (used != '0) &&
                    (free_cnt <= (wm_one ? PTR_W'(1) : PTR_W'(4)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      full_flags <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      overflow   <= 1'b0;
    end else if (reconfig) begin
      cfg_q      <= slot_is_tx;
      full_flags <= '0;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      overflow   <= 1'b0;
    end else begin
      if (do_wr) begin
        full_flags[wr_idx] <= 1'b1;
        wr_ptr             <= wr_nxt;
      end
      if (do_rd) begin
        full_flags[rd_idx] <= 1'b0;
        rd_ptr             <= rd_nxt;
      end
      if (accept && !do_wr) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rxfifo_pool_chk.sv
module rxfifo_pool_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int NUM_DED   = 2,
  parameter int PTR_W     = 4,
  localparam int NUM_PROG = NUM_SLOTS - NUM_DED,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PROG-1:0]  slot_is_tx,
  input logic                 accept,
  input logic                 clr_full,
  input logic [PTR_W-1:0]     clr_slot,
  input logic [NUM_SLOTS-1:0] full_flags,
  input logic [PTR_W-1:0]     wr_ptr,
  input logic [PTR_W-1:0]     rd_ptr,
  input logic [PTR_W-1:0]     depth,
  input logic                 rx_irq,
  input logic [4:0]           irq_code,
  input logic                 wm_irq,
  input logic                 overflow
);
  // R10
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(slot_is_tx) |-> (wr_ptr < depth) && (rd_ptr < depth)
      && ((full_flags >> depth) == '0));

  // R3
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(accept && full_flags[wr_ptr[IDX_W-1:0]]));

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && $stable(slot_is_tx) |=> overflow);

  // R2
  wr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(slot_is_tx) && accept && !full_flags[wr_ptr[IDX_W-1:0]]
      |=> wr_ptr != $past(wr_ptr));

  // R4
  rd_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(slot_is_tx) && clr_full && clr_slot == rd_ptr && full_flags[rd_ptr[IDX_W-1:0]]
      |=> rd_ptr != $past(rd_ptr));

  // R6
  irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flags == '0) |-> !rx_irq && irq_code == 5'b00000);

  // R7
  wm_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wm_irq |-> full_flags != '0);

  // R8
  reconfig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_is_tx) |=> full_flags == '0 && wr_ptr == '0 && rd_ptr == '0 && !overflow);
endmodule

bind rxfifo_pool rxfifo_pool_chk #(.NUM_SLOTS(NUM_SLOTS), .NUM_DED(NUM_DED), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/sim_rxfifo_pool.sv
module sim_rxfifo_pool;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [5:0] slot_is_tx = '0;
  logic wm_one = 0, accept = 0, clr_full = 0;
  logic [3:0] clr_slot = '0;
  logic [7:0] full_flags;
  logic [3:0] wr_ptr, rd_ptr, depth;
  logic empty, rx_irq, wm_irq, overflow;
  logic [4:0] irq_code;

  int n_chk = 0, n_bad = 0;
  int e_wr, e_rd, e_cnt, e_dep;
  bit e_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxfifo_pool u0 (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dep_of(logic [5:0] c);
    for (int i = 0; i < 6; i++) if (c[i]) return 2 + i;
    return 8;
  endfunction

  function automatic logic [7:0] flags_exp();
    logic [7:0] f = '0;
    for (int k = 0; k < e_cnt; k++) f[(e_rd + k) % e_dep] = 1'b1;
    return f;
  endfunction

  task automatic check_all(string req);
    logic [7:0] f = flags_exp();
    int fr = e_dep - e_cnt;
    bit wm = (e_cnt > 0) && (fr <= (wm_one ? 1 : 4));
    chk(depth == 4'(e_dep), {req, " R1 depth"}, depth, e_dep);
    chk(full_flags == f, {req, " R2 R4 flags"}, full_flags, f);
    chk(wr_ptr == 4'(e_wr), {req, " R2 wr_ptr"}, wr_ptr, e_wr);
    chk(rd_ptr == 4'(e_rd), {req, " R4 rd_ptr"}, rd_ptr, e_rd);
    chk(overflow == e_ovf, {req, " R3 overflow"}, overflow, e_ovf);
    chk(empty == (e_cnt == 0) && rx_irq == (e_cnt != 0), {req, " R6 empty"}, empty, e_cnt == 0);
    chk(irq_code == ((e_cnt != 0) ? 5'b10000 : 5'b00000), {req, " R6 code"}, irq_code,
        (e_cnt != 0) ? 16 : 0);
    chk(wm_irq == wm, {req, " R7 wm_irq"}, wm_irq, wm);
  endtask

  task automatic step(bit acc, bit clr, int slot, string req);
    bit full_at_wr = flags_exp() >> e_wr;
    bit dr = clr && slot == e_rd && e_cnt > 0;
    accept = acc; clr_full = clr; clr_slot = 4'(slot);
    @(posedge clk); #1;
    accept = 0; clr_full = 0;
    if (acc && !full_at_wr) begin e_cnt++; e_wr = (e_wr + 1) % e_dep; end
    else if (acc) e_ovf = 1;
    if (dr) begin e_cnt--; e_rd = (e_rd + 1) % e_dep; end
    check_all(req);
  endtask

  task automatic reconfig(logic [5:0] c);
    slot_is_tx = c;
    accept = 1; clr_full = 1; clr_slot = 4'(e_rd);
    @(posedge clk); #1;
    accept = 0; clr_full = 0;
    e_dep = dep_of(c); e_wr = 0; e_rd = 0; e_cnt = 0; e_ovf = 0;
    check_all("R8 reconfig");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] cfgs [8] = '{6'b000000, 6'b000001, 6'b000010, 6'b000100,
                             6'b001000, 6'b010100, 6'b100000, 6'b110000};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    e_dep = 8; e_wr = 0; e_rd = 0; e_cnt = 0; e_ovf = 0;
    check_all("R9 reset");
    for (int ci = 0; ci < 8; ci++) begin
      if (ci != 0) reconfig(cfgs[ci]);
      // fill past capacity: R2, R3, R7 with both thresholds
      for (int k = 0; k <= e_dep; k++) begin
        wm_one = k[0];
        step(1, 0, 0, "R2 R3 fill");
      end
      wm_one = 0; #1 check_all("R7 thr4");
      wm_one = 1; #1 check_all("R7 thr1");
      // non-head and out-of-range clears ignored
      step(0, 1, (e_rd + 1) % e_dep, "R5 non-head");
      step(0, 1, 15, "R5 out-of-range");
      // drain
      while (e_cnt > 0) step(0, 1, e_rd, "R4 drain");
      step(0, 1, e_rd, "R5 clear when empty");
      // stream with one item held, wrapping several times
      step(1, 0, 0, "R2 prime");
      for (int k = 0; k < 2 * e_dep + 1; k++) step(1, 1, e_rd, "R11 stream");
      // fill then simultaneous accept + head clear while full
      while (e_cnt < e_dep) step(1, 0, 0, "R2 refill");
      step(1, 1, e_rd, "R11 full both");
      step(1, 0, 0, "R11 refill one");
    end
    reconfig(6'b000000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule